// File: doc/BRIEF.md
# Processor Bus Address Decoder with Interrupt Source Readback

This block is the select logic beside an 8-bit processor that has a 16-bit address bus. It splits the address space into four kinds of region: a small RAM area, a slot for the peripheral interface chips, eight I/O windows and the program ROM. For each region it drives one active-low chip select. The address space is viewed as sixteen 4K pages. In every page, the lowest 1K belongs to RAM, except that the top 32 bytes of each 256-byte block in that 1K go to the peripheral chips. The upper 3K of pages 0 through 7 form I/O windows 0 through 7. ROM answers every address from 1000h upward that no other select claims, and only while phase 2 is high.

The block also merges six active-low option interrupt requests into the processor's single IRQ line. When the processor reads I/O window 0 with phase 2 high, the block puts the number of the highest-priority pending source on its readback data output and raises a drive enable. The pad buffer uses that enable to place the byte on the shared bus; at all other times the bus stays released.

Top module: `glue_decoder`

## Requirements
- R1: `ram_sel_n` is low exactly when the address offset within its 4K page (addr[11:0]) is at most 3FFh and the low byte (addr[7:0]) is below E0h.
- R2: `per_sel_n` is low exactly when addr[11:0] is at most 3FFh and addr[7:0] is E0h or above.
- R3: `io_sel_n[N]` is low exactly when addr[15:12] equals N (N from 0 to 7) and addr[11:0] is 400h or above. At most one I/O select is low at a time.
- R4: `rom_sel_n` is low exactly when addr is 1000h or above, `phi2` is high, and none of the RAM, peripheral or I/O selects is low. In practice this means addresses of 8000h and above whose offset in the page is 400h or more.
- R5: `irq_n` is low exactly when at least one bit of `ir_n` is low.
- R6: The interrupt code is the number of the lowest-numbered pending request. `ir_n[0]` is source 1 and has the highest priority; `ir_n[5]` is source 6 and has the lowest. The code is 0 when no request is pending.
- R7: `rb_oe` is high exactly when `io_sel_n[0]` is low, `rw` is 1 (read) and `phi2` is high. While `rb_oe` is high, `rb_data` carries the R6 code zero-extended to 8 bits. Otherwise `rb_data` is 00h.
- R8: At most one of the RAM, peripheral, ROM and I/O selects is low at any time.
- R9: The RAM, peripheral and I/O selects and `irq_n` do not depend on `phi2` or `rw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address bus |
| phi2 | input | 1 | Phase-2 clock level; high marks the data transfer phase |
| rw | input | 1 | 1 for a read, 0 for a write |
| ir_n | input | 6 | Option interrupt requests, active low; bit 0 is source 1 |
| ram_sel_n | output | 1 | RAM chip select, active low |
| per_sel_n | output | 1 | Peripheral interface chip select, active low |
| rom_sel_n | output | 1 | ROM output enable, active low, qualified by phase 2 |
| io_sel_n | output | 8 | I/O window selects, active low; bit N is window N |
| irq_n | output | 1 | Merged interrupt request to the processor, active low |
| rb_data | output | 8 | Interrupt source code for readback |
| rb_oe | output | 1 | Drive enable for the readback byte onto the data bus |

## Verification
The interrupt merge and the window-0 readback can act in the same cycle. A read of window 0 is in progress while the request lines change, so `irq_n` and the returned code must both follow the new request pattern at once. The bench holds a window-0 read with phase 2 high and walks all 64 request patterns under it, and it also switches individual requests on and off between reads. Each step is judged against a priority computed in the bench, and the readback code must be nonzero exactly when `irq_n` is low. A second overlap is the address decode against phase-2 qualification: the same addresses are applied with phase 2 low and then high, and only the ROM select and the readback may differ between the two.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int PAGE_W    = 12;
  localparam int BYTE_W    = 8;
  localparam int NUM_IO    = 8;
  localparam int NUM_IRQ   = 6;
  localparam int RAM_TOP   = 'h3FF;
  localparam int WIN_BASE  = 'h400;
  localparam int PER_BASE  = 'hE0;
  localparam int ROM_BASE  = 'h1000;
endpackage

// File: rtl/glue_map_dec.sv
module glue_map_dec
  import glue_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int PW      = PAGE_W,
  parameter int BW      = BYTE_W,
  parameter int NIO     = NUM_IO,
  parameter int RAM_HI  = RAM_TOP,
  parameter int WIN_LO  = WIN_BASE,
  parameter int PER_LO  = PER_BASE,
  parameter int ROM_LO  = ROM_BASE
) (
  input  logic [AW-1:0]  addr,
  input  logic           phi2,
  output logic           ram_hit,
  output logic           per_hit,
  output logic           rom_hit,
  output logic [NIO-1:0] io_hit
);
  localparam int SEL_W = AW - PW;
  localparam logic [PW-1:0] RAM_HI_V = PW'(RAM_HI);
  localparam logic [PW-1:0] WIN_LO_V = PW'(WIN_LO);
  localparam logic [BW-1:0] PER_LO_V = BW'(PER_LO);
  localparam logic [AW-1:0] ROM_LO_V = AW'(ROM_LO);

  logic [PW-1:0]    offset;
  logic [SEL_W-1:0] page;
  logic [BW-1:0]    low_byte;
  logic             low_area;

  assign offset   = addr[PW-1:0];
  assign page     = addr[AW-1:PW];
  assign low_byte = addr[BW-1:0];
  assign low_area = (offset <= RAM_HI_V);

  // One window per page, each covering the page above the low area
  for (genvar g = 0; g < NIO; g++) begin : g_win
    assign io_hit[g] = (page == SEL_W'(g)) && (offset >= WIN_LO_V);
  end

  assign per_hit = low_area && (low_byte >= PER_LO_V);
  assign ram_hit = low_area && !per_hit;
  // ROM is the default claimant above its base, qualified by phase 2
  assign rom_hit = (addr >= ROM_LO_V) && !low_area && !(|io_hit) && phi2;

  always_comb begin
    AST_IO_ONEHOT: assert ($onehot0(io_hit)) else $error("two I/O windows hit"); // R3
  end
endmodule

// File: rtl/glue_irq_prio.sv
module glue_irq_prio
  import glue_pkg::*;
#(
  parameter int NREQ = NUM_IRQ,
  parameter int CW   = $clog2(NUM_IRQ + 1)
) (
  input  logic [NREQ-1:0] req,
  output logic            any,
  output logic [CW-1:0]   code
);
  logic [NREQ:0]   clear_below;
  logic [NREQ-1:0] winner;

  assign clear_below[0] = 1'b1;
  // Ripple chain: a request wins only if every lower index is idle
  for (genvar i = 0; i < NREQ; i++) begin : g_chain
    assign winner[i]        = req[i] && clear_below[i];
    assign clear_below[i+1] = clear_below[i] && !req[i];
  end

  assign any = !clear_below[NREQ];

  always_comb begin
    code = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (winner[i]) code = code | CW'(i + 1);
    end
  end

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(winner)) else $error("several winners"); // R6
  end
endmodule

// File: rtl/glue_decoder.sv
module glue_decoder
  import glue_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int NIO  = NUM_IO,
  parameter int NREQ = NUM_IRQ
) (
  input  logic [AW-1:0]   addr,
  input  logic            phi2,
  input  logic            rw,
  input  logic [NREQ-1:0] ir_n,
  output logic            ram_sel_n,
  output logic            per_sel_n,
  output logic            rom_sel_n,
  output logic [NIO-1:0]  io_sel_n,
  output logic            irq_n,
  output logic [DW-1:0]   rb_data,
  output logic            rb_oe
);
  localparam int CW = $clog2(NREQ + 1);

  logic           ram_hit, per_hit, rom_hit;
  logic [NIO-1:0] io_hit;
  logic           req_any;
  logic [CW-1:0]  req_code;

  glue_map_dec #(.AW(AW), .NIO(NIO)) u_map (
    .addr    (addr),
    .phi2    (phi2),
    .ram_hit (ram_hit),
    .per_hit (per_hit),
    .rom_hit (rom_hit),
    .io_hit  (io_hit)
  );

  glue_irq_prio #(.NREQ(NREQ), .CW(CW)) u_prio (
    .req  (~ir_n),
    .any  (req_any),
    .code (req_code)
  );

  assign ram_sel_n = !ram_hit;
  assign per_sel_n = !per_hit;
  assign rom_sel_n = !rom_hit;
  assign io_sel_n  = ~io_hit;
  assign irq_n     = &ir_n;

  assign rb_oe   = io_hit[0] && rw && phi2;
  assign rb_data = rb_oe ? DW'(req_code) : '0;

  always_comb begin
    AST_SEL_EXCLUSIVE: assert ($countones({ram_hit, per_hit, rom_hit, io_hit}) <= 1)
      else $error("overlapping selects"); // R8
    AST_ROM_PHI2: assert (rom_sel_n || phi2) else $error("ROM without phase 2"); // R4
    AST_RB_WINDOW: assert (!rb_oe || !io_sel_n[0]) else $error("readback outside window 0"); // R7
    AST_IRQ_CODE: assert ((req_any && req_code != '0) == !irq_n)
      else $error("code and IRQ disagree"); // R6
    AST_RB_QUIET: assert (rb_oe || rb_data == '0) else $error("data while released"); // R7
  end
endmodule

// File: tb/glue_decoder_bench.sv
module glue_decoder_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       ram_n, per_n, rom_n, irq_n, oe;
    logic [7:0] io_n;
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [15:0] addr = '0;
  logic        phi2 = 1'b0, rw = 1'b1;
  logic [5:0]  ir_n = 6'h3F;
  logic        ram_sel_n, per_sel_n, rom_sel_n, irq_n, rb_oe;
  logic [7:0]  io_sel_n, rb_data;

  int   errors = 0, checks = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  glue_decoder u_glue_decoder (
    .addr(addr), .phi2(phi2), .rw(rw), .ir_n(ir_n),
    .ram_sel_n(ram_sel_n), .per_sel_n(per_sel_n), .rom_sel_n(rom_sel_n),
    .io_sel_n(io_sel_n), .irq_n(irq_n), .rb_data(rb_data), .rb_oe(rb_oe)
  );

  function automatic exp_t model(logic [15:0] a, logic p2, logic r, logic [5:0] irn, string tag);
    exp_t e;
    logic low, per, anyio;
    logic [7:0] code = 8'd0;
    low = a[11:0] <= 12'h3FF;
    per = low && a[7:0] >= 8'hE0;
    e.per_n = !per;
    e.ram_n = !(low && !per);
    for (int n = 0; n < 8; n++) e.io_n[n] = !(a[15:12] == 4'(n) && a[11:0] >= 12'h400);
    anyio = e.io_n != 8'hFF;
    e.rom_n = !(a >= 16'h1000 && !low && !anyio && p2);
    e.irq_n = (irn == 6'h3F);
    for (int i = 5; i >= 0; i--) if (!irn[i]) code = 8'(i + 1);
    e.oe   = !e.io_n[0] && r && p2;
    e.data = e.oe ? code : 8'h00;
    e.tag  = tag;
    return e;
  endfunction

  task automatic chk(bit ok, string req, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] a, logic p2, logic r, logic [5:0] irn, string tag);
    @(negedge clk);
    addr = a; phi2 = p2; rw = r; ir_n = irn;
    sb.push_back(model(a, p2, r, irn, tag));
  endtask

  // Monitor: outputs settle half a period after the drive edge
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(ram_sel_n == e.ram_n, "R1", e.tag, ram_sel_n, e.ram_n);
      chk(per_sel_n == e.per_n, "R2", e.tag, per_sel_n, e.per_n);
      chk(io_sel_n == e.io_n, "R3", e.tag, io_sel_n, e.io_n);
      chk(rom_sel_n == e.rom_n, "R4", e.tag, rom_sel_n, e.rom_n);
      chk(irq_n == e.irq_n, "R5", e.tag, irq_n, e.irq_n);
      chk(rb_oe == e.oe, "R7", e.tag, rb_oe, e.oe);
      chk(rb_data == e.data, "R6", e.tag, rb_data, e.data);
      chk($countones({~ram_sel_n, ~per_sel_n, ~rom_sel_n, ~io_sel_n}) <= 1, "R8",
          e.tag, $countones({~ram_sel_n, ~per_sel_n, ~rom_sel_n, ~io_sel_n}), 1);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [16] = '{16'h0000, 16'h03DF, 16'h03E0, 16'h03FF, 16'h0400, 16'h0FFF,
                               16'h1000, 16'h13FF, 16'h1400, 16'h7FFF, 16'h8000, 16'h83E5,
                               16'h8400, 16'hFFFF, 16'hF3FF, 16'h75E0};
    drive(16'h0000, 1'b0, 1'b1, 6'h3F, "idle");
    // R1 R2 R3 R4 boundaries, phase 2 low then high (R9: only ROM may change)
    foreach (edges[k]) begin
      drive(edges[k], 1'b0, 1'b1, 6'h3F, "edge p2 low");
      drive(edges[k], 1'b1, 1'b1, 6'h3F, "edge p2 high");
      drive(edges[k], 1'b1, 1'b0, 6'h3F, "edge write");
    end
    // R5 R6: each single request during a window-0 read
    for (int i = 0; i < 6; i++) drive(16'h0400, 1'b1, 1'b1, ~(6'b1 << i), "single req");
    // R5 R6 R7: every request pattern under a held window-0 read
    for (int p = 0; p < 64; p++) drive(16'h0A55, 1'b1, 1'b1, 6'(p), "pattern read");
    // R7: same requests, readback blocked by write, by phase 2 and by another window
    drive(16'h0A55, 1'b1, 1'b0, 6'b110101, "win0 write");
    drive(16'h0A55, 1'b0, 1'b1, 6'b110101, "win0 p2 low");
    drive(16'h1A55, 1'b1, 1'b1, 6'b110101, "win1 read");
    // Request changing between reads
    drive(16'h0400, 1'b1, 1'b1, 6'b011111, "req6 only");
    drive(16'h0400, 1'b1, 1'b1, 6'b011011, "req3 arrives");
    drive(16'h0400, 1'b1, 1'b1, 6'b011110, "req1 arrives");
    drive(16'h0400, 1'b1, 1'b1, 6'b111111, "all clear");
    // Address sweep with mixed controls
    for (int s = 0; s < 512; s++)
      drive(16'(s * 16'h0083), 1'(s % 2), 1'(s % 3 != 0), 6'(s % 64), "sweep");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule